// File: doc/BRIEF.md
# Configuration-Space Target for a Single-Function Bus Device

This block answers configuration cycles on a PCI-style parallel bus for a device with one function. In the address phase it samples the 32-bit address/data lines, the 4-bit command and the chip-select line for configuration. From these it decides whether the cycle belongs to it. A claimed configuration read returns one dword from a 16-dword header. A claimed configuration write merges the data phase into that header, per byte lane and per writable bit. The header holds the identity words, the command and status word, the class code, two memory base address registers and the interrupt line.

Memory cycles are also decoded. They are claimed only after software has set the memory-decode bit in the command word, and only when the address falls inside one of the programmed base-address windows. The memory controller behind those windows lies outside this block. The handshake is reduced to a single strobe for the address phase. It is followed by exactly one data phase, in which the response is presented and any write data is taken.

Top module: `cfg_target`

## Requirements
- R1: After reset no response is pending and every writable header bit is 0: the command dword, both base address dwords, the cache-line/latency dword and the interrupt-line byte all read as zero, and memory cycles are not claimed.
- R2: A strobe sampled at a clock edge when no data phase is pending gives `resp_valid` high for exactly the following cycle (the data phase). A configuration read (command 1010) or write (command 1011) is claimed when `idsel` is high, address bits [1:0] are 00 and address bits [10:8] are 000.
- R3: An unclaimed cycle always returns `rd_data` = FFFFFFFF with `claimed` low. A configuration cycle whose address bits [1:0] are not 00, or one with `idsel` low, is unclaimed, and its write changes nothing.
- R4: A configuration cycle that names a nonzero function (address bits [10:8] not 000) is unclaimed, reads as FFFFFFFF, and its write changes nothing.
- R5: The register number is address bits [7:2]. A claimed configuration read of register 16 to 63 returns 0, and a write there changes no header register.
- R6: Register 0 reads {device ID 3C4D, vendor ID 1A2B}. Register 2 reads {base class 01, sub-class 06, programming interface 01, revision 02} from bit 31 down. Register 11 reads {5E6F, 1A2B}. Writes to these three leave them unchanged.
- R7: Write byte enables are active low, with lane n covering bits [8n+7:8n]. Only writable bits change. These are command bits 1, 2, 6 and 8 of register 1 (the upper half is read-only zero), bits [15:0] of register 3, and bits [7:0] of register 15. Bits [15:8] of register 15 read 01 as the interrupt pin.
- R8: Register 4 is a 4 KiB memory window and register 5 a 256 B window. Only address bits at or above the window size are writable, and the lower bits, including attribute bits [3:0] = 0000 (32-bit, non-prefetchable, memory), read 0. Writing all ones reads back FFFFF000 and FFFFFF00.
- R9: A memory read (0110) or write (0111) is claimed only when command bit 1 is set and the address matches a base register above its window size. A claimed memory cycle returns `rd_data` = 0.
- R10: Any command other than the four above is never claimed.
- R11: A strobe that arrives while a data phase is pending is ignored and produces no second response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strobe | input | 1 | Address phase marker, one cycle |
| ad_addr | input | 32 | Address lines sampled with the strobe |
| cbe_cmd | input | 4 | Bus command sampled with the strobe |
| idsel | input | 1 | Configuration select, sampled with the strobe |
| wdata | input | 32 | Write data, taken during the data phase |
| be_n | input | 4 | Active-low byte enables, taken during the data phase |
| resp_valid | output | 1 | High during the data phase |
| claimed | output | 1 | Cycle was accepted by this device (valid with resp_valid) |
| rd_data | output | 32 | Read data (valid with resp_valid) |

## Verification
A strobe sampled at edge k gives its response (`resp_valid`, `claimed`, `rd_data`) in the cycle between edges k and k+1. The write data from that same cycle is committed at edge k+1, so a read strobed at k+2 or later already sees it. The bench drives every input on the falling edge. Its behavioural model advances on each rising edge by the same counting. The outputs are compared to the model on every falling edge, so each result is checked in the one cycle where it is due and no other. Every write is followed by a read-back through a later configuration read, so writes that should be dropped are checked at the ports.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    localparam int unsigned HDR_DWORDS = 16;
    localparam int unsigned BAR_FIRST  = 4;
    localparam int unsigned BAR_MAX    = 6;

    // writable command bits: memory decode, bus-master, parity response, error driver enable
    localparam logic [15:0] CMD_WMASK = 16'h0146;
    localparam int unsigned MEM_EN_BIT = 1;

    typedef enum logic [2:0] {
        K_NONE,
        K_CFG_RD,
        K_CFG_WR,
        K_MEM_RD,
        K_MEM_WR
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e  kind;
        logic        claim;
        logic [5:0]  regnum;
    } xfer_dec_t;

endpackage

// File: rtl/cfgt_bar_hit.sv
module cfgt_bar_hit #(
    parameter int unsigned              NUM_BARS    = 2,
    parameter logic [NUM_BARS*8-1:0]    BAR_SZ_LOG2 = 16'h080C
) (
    input  logic [31:0]                 addr,
    input  logic [NUM_BARS-1:0][31:0]   bar_base,
    output logic                        hit
);

    logic [NUM_BARS-1:0] hit_vec;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_win
        localparam int unsigned SZ     = int'(BAR_SZ_LOG2[g*8 +: 8]);
        localparam logic [31:0] WIN_MASK = ~((32'd1 << SZ) - 32'd1);
        assign hit_vec[g] = (((addr ^ bar_base[g]) & WIN_MASK) == 32'd0);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/cfgt_decode.sv
module cfgt_decode
    import cfgt_pkg::*;
(
    input  logic [31:0] ad_addr,
    input  logic [3:0]  cbe_cmd,
    input  logic        idsel,
    input  logic        mem_en,
    input  logic        bar_hit,
    output xfer_dec_t   dec
);

    logic cfg_sel;
    logic type0;
    logic func0;

    always_comb begin
        type0   = (ad_addr[1:0] == 2'b00);
        func0   = (ad_addr[10:8] == 3'b000);
        cfg_sel = idsel && type0 && func0;

        dec        = '0;
        dec.kind   = K_NONE;
        dec.regnum = ad_addr[7:2];

        case (cbe_cmd)
            CMD_CFG_RD: begin
                dec.kind  = K_CFG_RD;
                dec.claim = cfg_sel;
            end
            CMD_CFG_WR: begin
                dec.kind  = K_CFG_WR;
                dec.claim = cfg_sel;
            end
            CMD_MEM_RD: begin
                dec.kind  = K_MEM_RD;
                dec.claim = mem_en && bar_hit;
            end
            CMD_MEM_WR: begin
                dec.kind  = K_MEM_WR;
                dec.claim = mem_en && bar_hit;
            end
            default: begin
                dec.kind  = K_NONE;
                dec.claim = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cfgt_regfile.sv
module cfgt_regfile
    import cfgt_pkg::*;
#(
    parameter logic [15:0]              VENDOR_ID   = 16'h1A2B,
    parameter logic [15:0]              DEVICE_ID   = 16'h3C4D,
    parameter logic [7:0]               REVISION    = 8'h02,
    parameter logic [7:0]               BASE_CLASS  = 8'h01,
    parameter logic [7:0]               SUB_CLASS   = 8'h06,
    parameter logic [7:0]               PROG_IF     = 8'h01,
    parameter logic [15:0]              SUBSYS_VID  = 16'h1A2B,
    parameter logic [15:0]              SUBSYS_ID   = 16'h5E6F,
    parameter logic [7:0]               IRQ_PIN     = 8'h01,
    parameter int unsigned              NUM_BARS    = 2,
    parameter logic [NUM_BARS*8-1:0]    BAR_SZ_LOG2 = 16'h080C
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [3:0]                  wr_idx,
    input  logic [31:0]                 wr_data,
    input  logic [3:0]                  wr_be_n,
    input  logic [3:0]                  rd_idx,
    output logic [31:0]                 rd_data,
    output logic                        mem_en,
    output logic [NUM_BARS-1:0][31:0]   bar_base
);

    typedef struct packed {
        logic [15:0]                cmd;
        logic [7:0]                 lat_timer;
        logic [7:0]                 cache_line;
        logic [7:0]                 irq_line;
        logic [NUM_BARS-1:0][31:0]  bar;
    } hdr_state_t;

    hdr_state_t st_d, st_q;

    function automatic logic [31:0] bar_mask(input int unsigned idx);
        int unsigned sz;
        sz = int'(BAR_SZ_LOG2[idx*8 +: 8]);
        return ~((32'd1 << sz) - 32'd1);
    endfunction

    function automatic logic [31:0] wr_mask(input logic [3:0] idx);
        logic [31:0] m;
        case (idx)
            4'd1:    m = {16'h0000, CMD_WMASK};
            4'd3:    m = 32'h0000_FFFF;
            4'd15:   m = 32'h0000_00FF;
            default: m = 32'h0000_0000;
        endcase
        for (int i = 0; i < NUM_BARS; i++) begin
            if (idx == 4'(BAR_FIRST + i)) m = bar_mask(i);
        end
        return m;
    endfunction

    function automatic logic [31:0] dword_of(input hdr_state_t s, input logic [3:0] idx);
        logic [31:0] v;
        case (idx)
            4'd0:    v = {DEVICE_ID, VENDOR_ID};
            4'd1:    v = {16'h0000, s.cmd};
            4'd2:    v = {BASE_CLASS, SUB_CLASS, PROG_IF, REVISION};
            4'd3:    v = {8'h00, 8'h00, s.lat_timer, s.cache_line};
            4'd11:   v = {SUBSYS_ID, SUBSYS_VID};
            4'd15:   v = {8'h00, 8'h00, IRQ_PIN, s.irq_line};
            default: v = 32'h0000_0000;
        endcase
        for (int i = 0; i < NUM_BARS; i++) begin
            if (idx == 4'(BAR_FIRST + i)) v = s.bar[i];
        end
        return v;
    endfunction

    logic [31:0] lane_mask;
    logic [31:0] merge_mask;
    logic [31:0] cur_word;
    logic [31:0] new_word;

    always_comb begin
        lane_mask  = {{8{~wr_be_n[3]}}, {8{~wr_be_n[2]}}, {8{~wr_be_n[1]}}, {8{~wr_be_n[0]}}};
        merge_mask = wr_mask(wr_idx) & lane_mask;
        cur_word   = dword_of(st_q, wr_idx);
        new_word   = (cur_word & ~merge_mask) | (wr_data & merge_mask);

        st_d = st_q;
        if (wr_en) begin
            case (wr_idx)
                4'd1: st_d.cmd = new_word[15:0];
                4'd3: begin
                    st_d.cache_line = new_word[7:0];
                    st_d.lat_timer  = new_word[15:8];
                end
                4'd15: st_d.irq_line = new_word[7:0];
                default: ;
            endcase
            for (int i = 0; i < NUM_BARS; i++) begin
                if (wr_idx == 4'(BAR_FIRST + i)) st_d.bar[i] = new_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = dword_of(st_q, rd_idx);
    assign mem_en   = st_q.cmd[MEM_EN_BIT];
    assign bar_base = st_q.bar;

endmodule

// File: rtl/cfg_target.sv
module cfg_target
    import cfgt_pkg::*;
#(
    parameter logic [15:0]              VENDOR_ID   = 16'h1A2B,
    parameter logic [15:0]              DEVICE_ID   = 16'h3C4D,
    parameter logic [7:0]               REVISION    = 8'h02,
    parameter logic [7:0]               BASE_CLASS  = 8'h01,
    parameter logic [7:0]               SUB_CLASS   = 8'h06,
    parameter logic [7:0]               PROG_IF     = 8'h01,
    parameter logic [15:0]              SUBSYS_VID  = 16'h1A2B,
    parameter logic [15:0]              SUBSYS_ID   = 16'h5E6F,
    parameter logic [7:0]               IRQ_PIN     = 8'h01,
    parameter int unsigned              NUM_BARS    = 2,
    parameter logic [NUM_BARS*8-1:0]    BAR_SZ_LOG2 = 16'h080C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_strobe,
    input  logic [31:0] ad_addr,
    input  logic [3:0]  cbe_cmd,
    input  logic        idsel,
    input  logic [31:0] wdata,
    input  logic [3:0]  be_n,
    output logic        resp_valid,
    output logic        claimed,
    output logic [31:0] rd_data
);

    localparam logic [5:0] HDR_LIMIT = 6'(HDR_DWORDS);

    typedef struct packed {
        logic        busy;
        xfer_kind_e  kind;
        logic        claim;
        logic [5:0]  regnum;
        logic [31:0] rdata;
    } phase_t;

    phase_t st_d, st_q;

    logic                       mem_en;
    logic [NUM_BARS-1:0][31:0]  bar_base;
    logic                       bar_hit;
    xfer_dec_t                  dec;
    logic [31:0]                hdr_rd;
    logic                       hdr_wr;
    xfer_kind_e                 cur_kind;

    cfgt_bar_hit #(
        .NUM_BARS    (NUM_BARS),
        .BAR_SZ_LOG2 (BAR_SZ_LOG2)
    ) u_bar_hit (
        .addr     (ad_addr),
        .bar_base (bar_base),
        .hit      (bar_hit)
    );

    cfgt_decode u_decode (
        .ad_addr (ad_addr),
        .cbe_cmd (cbe_cmd),
        .idsel   (idsel),
        .mem_en  (mem_en),
        .bar_hit (bar_hit),
        .dec     (dec)
    );

    cfgt_regfile #(
        .VENDOR_ID   (VENDOR_ID),
        .DEVICE_ID   (DEVICE_ID),
        .REVISION    (REVISION),
        .BASE_CLASS  (BASE_CLASS),
        .SUB_CLASS   (SUB_CLASS),
        .PROG_IF     (PROG_IF),
        .SUBSYS_VID  (SUBSYS_VID),
        .SUBSYS_ID   (SUBSYS_ID),
        .IRQ_PIN     (IRQ_PIN),
        .NUM_BARS    (NUM_BARS),
        .BAR_SZ_LOG2 (BAR_SZ_LOG2)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hdr_wr),
        .wr_idx   (st_q.regnum[3:0]),
        .wr_data  (wdata),
        .wr_be_n  (be_n),
        .rd_idx   (ad_addr[5:2]),
        .rd_data  (hdr_rd),
        .mem_en   (mem_en),
        .bar_base (bar_base)
    );

    always_comb begin
        hdr_wr = st_q.busy && st_q.claim && (st_q.kind == K_CFG_WR)
                 && (st_q.regnum < HDR_LIMIT);

        st_d      = st_q;
        st_d.busy = 1'b0;

        if (!st_q.busy && addr_strobe) begin
            st_d.busy   = 1'b1;
            st_d.kind   = dec.kind;
            st_d.claim  = dec.claim;
            st_d.regnum = dec.regnum;
            if (!dec.claim) begin
                st_d.rdata = 32'hFFFF_FFFF;
            end else if (dec.kind == K_CFG_RD && dec.regnum < HDR_LIMIT) begin
                st_d.rdata = hdr_rd;
            end else begin
                st_d.rdata = 32'h0000_0000;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= K_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.busy;
    assign claimed    = st_q.busy && st_q.claim;
    assign rd_data    = st_q.busy ? st_q.rdata : 32'h0000_0000;
    assign cur_kind   = st_q.kind;

endmodule

module cfg_target_chk
    import cfgt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        addr_strobe,
    input logic        resp_valid,
    input logic        claimed,
    input logic [31:0] rd_data,
    input xfer_kind_e  resp_kind,
    input logic        mem_en
);

    logic is_mem;
    assign is_mem = (resp_kind == K_MEM_RD) || (resp_kind == K_MEM_WR);

    // R2: a strobe seen while idle is answered in the next cycle
    assert_resp_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && !resp_valid) |=> resp_valid);

    // R2: no response without a strobe one edge earlier
    assert_resp_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(addr_strobe));

    // R11: a data phase lasts one cycle, overlapping strobes do not extend it
    assert_single_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R3: unclaimed cycles return all ones
    assert_unclaimed_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !claimed) |-> (rd_data == 32'hFFFF_FFFF));

    // R9: memory cycles are claimed only with memory decode enabled
    assert_mem_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && claimed && is_mem) |-> $past(mem_en));

    // R9: a claimed memory cycle carries zero data
    assert_mem_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && claimed && is_mem) |-> (rd_data == 32'h0000_0000));

endmodule

bind cfg_target cfg_target_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_strobe (addr_strobe),
    .resp_valid  (resp_valid),
    .claimed     (claimed),
    .rd_data     (rd_data),
    .resp_kind   (cur_kind),
    .mem_en      (mem_en)
);

// File: tb/cfg_target_tb_top.sv
`timescale 1ns/100ps
module cfg_target_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_strobe = 1'b0;
    logic [31:0] ad_addr = '0;
    logic [3:0]  cbe_cmd = '0;
    logic        idsel = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  be_n = 4'hF;
    logic        resp_valid;
    logic        claimed;
    logic [31:0] rd_data;

    int vectors = 0;
    int misses  = 0;
    logic done = 1'b0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    cfg_target dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_strobe (addr_strobe),
        .ad_addr     (ad_addr),
        .cbe_cmd     (cbe_cmd),
        .idsel       (idsel),
        .wdata       (wdata),
        .be_n        (be_n),
        .resp_valid  (resp_valid),
        .claimed     (claimed),
        .rd_data     (rd_data)
    );

    // ---------------- behavioural reference model ----------------
    logic        m_valid = 1'b0;
    logic        m_claim = 1'b0;
    logic        m_iswr  = 1'b0;
    int          m_reg   = 0;
    logic [31:0] m_rd    = '0;
    string       m_tag   = "R1";
    logic [15:0] m_cmd   = '0;
    logic [7:0]  m_cls   = '0;
    logic [7:0]  m_lat   = '0;
    logic [7:0]  m_irq   = '0;
    logic [31:0] m_bar0  = '0;
    logic [31:0] m_bar1  = '0;

    function automatic logic [31:0] model_read(input int rn);
        case (rn)
            0:  return 32'h3C4D_1A2B;
            1:  return {16'h0, m_cmd};
            2:  return 32'h0106_0102;
            3:  return {16'h0, m_lat, m_cls};
            4:  return m_bar0;
            5:  return m_bar1;
            11: return 32'h5E6F_1A2B;
            15: return {16'h0, 8'h01, m_irq};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_wmask(input int rn);
        case (rn)
            1:  return 32'h0000_0146;
            3:  return 32'h0000_FFFF;
            4:  return 32'hFFFF_F000;
            5:  return 32'hFFFF_FF00;
            15: return 32'h0000_00FF;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_cmd <= '0; m_cls <= '0; m_lat <= '0; m_irq <= '0;
            m_bar0 <= '0; m_bar1 <= '0;
        end else if (m_valid) begin
            logic [31:0] lanes, msk, nw;
            m_valid <= 1'b0;
            if (m_claim && m_iswr && m_reg < 16) begin
                lanes = 32'h0;
                for (int b = 0; b < 4; b++) if (!be_n[b]) lanes[b*8 +: 8] = 8'hFF;
                msk = model_wmask(m_reg) & lanes;
                nw  = (model_read(m_reg) & ~msk) | (wdata & msk);
                case (m_reg)
                    1:  m_cmd <= nw[15:0];
                    3:  begin m_cls <= nw[7:0]; m_lat <= nw[15:8]; end
                    4:  m_bar0 <= nw;
                    5:  m_bar1 <= nw;
                    15: m_irq <= nw[7:0];
                    default: ;
                endcase
            end
        end else if (addr_strobe) begin
            logic cl, in_win;
            int rn;
            rn = int'(ad_addr[7:2]);
            in_win = ((ad_addr & 32'hFFFF_F000) == m_bar0) || ((ad_addr & 32'hFFFF_FF00) == m_bar1);
            case (cbe_cmd)
                4'b1010, 4'b1011: cl = idsel && ad_addr[1:0] == 2'b00 && ad_addr[10:8] == 3'b000;
                4'b0110, 4'b0111: cl = m_cmd[1] && in_win;
                default:          cl = 1'b0;
            endcase
            m_valid <= 1'b1;
            m_claim <= cl;
            m_iswr  <= (cbe_cmd == 4'b1011);
            m_reg   <= rn;
            m_tag   <= cur_tag;
            if (!cl)                              m_rd <= 32'hFFFF_FFFF;
            else if (cbe_cmd == 4'b1010 && rn < 16) m_rd <= model_read(rn);
            else                                  m_rd <= 32'h0;
        end
    end

    // ---------------- compare on every clock ----------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (resp_valid !== m_valid) begin
                misses++;
                $display("FAIL %s: resp_valid=%0b expected %0b", m_valid ? m_tag : "R2", resp_valid, m_valid);
            end else if (m_valid && (claimed !== m_claim || rd_data !== m_rd)) begin
                misses++;
                $display("FAIL %s: claimed=%0b rd_data=%h expected claimed=%0b rd_data=%h",
                         m_tag, claimed, rd_data, m_claim, m_rd);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic xfer(input logic [3:0] c, input logic [31:0] a, input logic sel,
                        input logic [31:0] d, input logic [3:0] ben, input string tag);
        @(negedge clk);
        cur_tag = tag; addr_strobe = 1'b1; ad_addr = a; cbe_cmd = c; idsel = sel;
        @(negedge clk);
        addr_strobe = 1'b0; idsel = 1'b0; wdata = d; be_n = ben;
        @(negedge clk);
        wdata = '0; be_n = 4'hF;
    endtask

    task automatic cfg_rd(input int rn, input string tag);
        xfer(4'b1010, 32'(rn) << 2, 1'b1, 32'h0, 4'hF, tag);
    endtask

    task automatic cfg_wr(input int rn, input logic [31:0] d, input logic [3:0] ben, input string tag);
        xfer(4'b1011, 32'(rn) << 2, 1'b1, d, ben, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (resp_valid !== 1'b0 || claimed !== 1'b0) begin
            misses++;
            $display("FAIL R1: resp_valid=%0b claimed=%0b expected 0 0", resp_valid, claimed);
        end
    endtask

    initial begin
        do_reset();
        // R1: reset values
        cfg_rd(1, "R1"); cfg_rd(3, "R1"); cfg_rd(4, "R1"); cfg_rd(5, "R1"); cfg_rd(15, "R1");
        // R6: identity words, read-only
        cfg_rd(0, "R6"); cfg_rd(2, "R6"); cfg_rd(11, "R6");
        cfg_wr(0, 32'hFFFF_FFFF, 4'h0, "R6"); cfg_rd(0, "R6");
        cfg_wr(2, 32'h0000_0000, 4'h0, "R6"); cfg_rd(2, "R6");
        cfg_wr(11, 32'h1234_5678, 4'h0, "R6"); cfg_rd(11, "R6");
        // R7: byte lanes and writable bits
        cfg_wr(1, 32'hFFFF_FFFF, 4'h0, "R7"); cfg_rd(1, "R7");
        cfg_wr(1, 32'h0000_0000, 4'hE, "R7"); cfg_rd(1, "R7");
        cfg_wr(3, 32'hAABB_CCDD, 4'hD, "R7"); cfg_rd(3, "R7");
        cfg_wr(3, 32'h1122_3344, 4'hE, "R7"); cfg_rd(3, "R7");
        cfg_wr(15, 32'hFFFF_FFFF, 4'h0, "R7"); cfg_rd(15, "R7");
        cfg_wr(15, 32'h0000_0000, 4'hF, "R7"); cfg_rd(15, "R7");
        // R8: base address sizing
        cfg_wr(4, 32'hFFFF_FFFF, 4'h0, "R8"); cfg_rd(4, "R8");
        cfg_wr(5, 32'hFFFF_FFFF, 4'h0, "R8"); cfg_rd(5, "R8");
        cfg_wr(4, 32'h1234_5678, 4'h0, "R8"); cfg_rd(4, "R8");
        cfg_wr(5, 32'h00AB_CDEF, 4'h3, "R8"); cfg_rd(5, "R8");
        cfg_wr(5, 32'h00AB_CDEF, 4'h0, "R8"); cfg_rd(5, "R8");
        // R3: type 1 and deselected cycles
        xfer(4'b1010, 32'h0000_0001, 1'b1, 32'h0, 4'hF, "R3");
        xfer(4'b1011, 32'h0000_000D, 1'b1, 32'hFFFF_FFFF, 4'h0, "R3"); cfg_rd(3, "R3");
        xfer(4'b1010, 32'h0000_0000, 1'b0, 32'h0, 4'hF, "R3");
        xfer(4'b1011, 32'h0000_003C, 1'b0, 32'h0000_00AA, 4'h0, "R3"); cfg_rd(15, "R3");
        // R4: nonzero function
        xfer(4'b1010, 32'h0000_0100, 1'b1, 32'h0, 4'hF, "R4");
        xfer(4'b1011, 32'h0000_070C, 1'b1, 32'hFFFF_FFFF, 4'h0, "R4"); cfg_rd(3, "R4");
        // R5: register numbers above 15
        cfg_rd(20, "R5"); cfg_rd(63, "R5");
        cfg_wr(20, 32'hFFFF_FFFF, 4'h0, "R5"); cfg_rd(4, "R5");
        cfg_wr(17, 32'hFFFF_FFFF, 4'h0, "R5"); cfg_rd(1, "R5");
        // R9: memory decode gated by enable and windows
        xfer(4'b0110, 32'h1234_5010, 1'b0, 32'h0, 4'hF, "R9");
        cfg_wr(1, 32'h0000_0002, 4'hE, "R9"); cfg_rd(1, "R9");
        xfer(4'b0110, 32'h1234_5ABC, 1'b0, 32'h0, 4'hF, "R9");
        xfer(4'b0111, 32'h1234_5FFC, 1'b0, 32'h55AA_55AA, 4'h0, "R9");
        xfer(4'b0110, 32'h1234_6000, 1'b0, 32'h0, 4'hF, "R9");
        xfer(4'b0110, 32'h00AB_CD7F, 1'b0, 32'h0, 4'hF, "R9");
        xfer(4'b0110, 32'h00AB_CE00, 1'b0, 32'h0, 4'hF, "R9");
        xfer(4'b1010, 32'h1234_5000, 1'b0, 32'h0, 4'hF, "R9");
        // R10: other commands never claimed
        xfer(4'b0000, 32'h1234_5000, 1'b1, 32'h0, 4'hF, "R10");
        xfer(4'b1100, 32'h1234_5000, 1'b1, 32'h0, 4'hF, "R10");
        xfer(4'b0010, 32'h0000_0000, 1'b1, 32'h0, 4'hF, "R10");
        xfer(4'b1111, 32'h0000_0004, 1'b1, 32'hFFFF_FFFF, 4'h0, "R10"); cfg_rd(1, "R10");
        cfg_wr(1, 32'h0000_0000, 4'hE, "R9");
        xfer(4'b0110, 32'h1234_5ABC, 1'b0, 32'h0, 4'hF, "R9");
        // R11: strobe during the data phase is ignored
        @(negedge clk);
        cur_tag = "R11"; addr_strobe = 1'b1; ad_addr = 32'h0000_0008; cbe_cmd = 4'b1010; idsel = 1'b1;
        @(negedge clk);
        ad_addr = 32'h0000_000C; cbe_cmd = 4'b1011; wdata = 32'hFFFF_FFFF; be_n = 4'h0;
        @(negedge clk);
        addr_strobe = 1'b0; idsel = 1'b0; wdata = '0; be_n = 4'hF;
        @(negedge clk);
        cfg_rd(3, "R11");
        // R1: reset in mid-run clears writable state
        do_reset();
        cfg_rd(1, "R1"); cfg_rd(3, "R1"); cfg_rd(4, "R1"); cfg_rd(5, "R1"); cfg_rd(15, "R1");
        xfer(4'b0110, 32'h0000_0000, 1'b0, 32'h0, 4'hF, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: run did not end, actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule